// File: doc/BRIEF.md
# Early-Late Peak Detector with Preamble Sync

This block sits after a resettable integrator in a binary phase-shift receiver. On every sample strobe it takes the signed integrator value into a three-deep window. The window holds an early sample (the oldest), a present sample (the middle) and a late sample (the newest). A bit peak is declared when the present magnitude is strictly larger than both neighbours and is at least a programmable threshold. The test uses absolute values and comparators only, with no multipliers.

Each peak produces a sliced bit taken from the sign of the present sample. While the block is unlocked, these bits shift into a 16-bit history that is compared against a stored preamble. Once the whole preamble has been seen, the sync-lock flag rises. From then on, every peak emits a data bit with a one-cycle valid strobe. The data bit is the sign of the integrator sample at the peak. If peaks stop arriving for two nominal bit periods, lock drops and the matcher starts again from an empty history.

Top module: `elsPeakSync`

## Requirements
- R1: After reset, peakStb, syncLock and dataValid are all 0.
- R2: When the window holds three samples taken since reset and |present| > |early|, |present| > |late| and |present| >= threshold, peakStb is high for exactly one cycle. That cycle is the second clock after the edge that captures the late sample. Two consecutive cycles never both show a peak.
- R3: Equal magnitudes do not count as a peak, because both comparisons are strict. A present magnitude below threshold gives no peak. A magnitude exactly equal to threshold does give a peak.
- R4: Magnitude is the absolute value of the two's-complement sample. Negative peaks are detected like positive ones, and the most negative code has magnitude 2^(DATA_W-1).
- R5: The sliced bit of a peak is 1 when the present sample is >= 0, and 0 when it is negative.
- R6: While unlocked, each peak shifts its sliced bit into bit 0 of a 16-bit history. syncLock rises one cycle after the peak whose bit makes the history equal PREAMBLE. PREAMBLE bit 15 is the first bit received.
- R7: dataValid is never high while unlocked. The peak that completes the preamble produces no data.
- R8: While locked, each peak gives dataValid for one cycle, one cycle after peakStb, with dataBit equal to that peak's sliced bit.
- R9: While locked, if 2*SAMPLES_PER_BIT sample strobes pass since the last peak, syncLock clears and the history is emptied.
- R10: After a loss, lock returns only after all 16 preamble bits have been received again. A partial preamble does not relock.
- R11: sampleIn is ignored in cycles where sampleStb is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleIn | input | DATA_W | Signed integrator value |
| sampleStb | input | 1 | Sample valid strobe |
| threshold | input | DATA_W | Unsigned minimum peak magnitude |
| peakStb | output | 1 | One-cycle peak pulse |
| syncLock | output | 1 | Preamble lock flag |
| dataBit | output | 1 | Recovered bit |
| dataValid | output | 1 | One-cycle strobe for dataBit |

## Verification
The bench drives the most negative sample code. A design that takes the absolute value in the signed domain would wrap this code to a negative number and miss the peak.

It also drives flat plateaus and a peak that equals the threshold exactly. A comparator with the wrong strictness would fire on the plateau or stay silent at the threshold.

After a loss of lock, the bench sends a partial preamble. A matcher that kept its old history would relock on those bits.

Last, it checks that nothing is emitted while unlocked, and that lock survives short gaps but drops after two bit periods of silence. An off-by-one or inverted gating in the loss counter shows up as a wrong lock level.

// File: rtl/elsPkg.sv
package elsPkg;
  // Strobes handed from the sample datapath to the sync control
  typedef struct packed {
    logic peak;   // peak found in the window
    logic slice;  // sign slice of the present sample at the peak
    logic tick;   // one sample strobe has been absorbed
  } peakEvt_t;
endpackage

// File: rtl/elsPeakPath.sv
module elsPeakPath
  import elsPkg::*;
#(
  parameter int DATA_W = 13
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [DATA_W-1:0] sampleIn,
  input  logic                     sampleStb,
  input  logic        [DATA_W-1:0] threshold,
  output peakEvt_t                 evt
);
  localparam int MSB = DATA_W - 1;

  logic signed [DATA_W-1:0] earlyQ, presentQ, lateQ;
  logic [1:0] fillQ;
  logic       freshQ;
  logic       peakQ, sliceQ, tickQ;

  // Unsigned magnitude; the most negative code maps to 2^(DATA_W-1)
  function automatic logic [DATA_W-1:0] magOf(input logic signed [DATA_W-1:0] v);
    logic [DATA_W-1:0] raw;
    raw = v;
    return v[MSB] ? (~raw + 1'b1) : raw;
  endfunction

  logic [DATA_W-1:0] eMag, pMag, lMag;
  logic isPeak;

  always_comb begin
    eMag   = magOf(earlyQ);
    pMag   = magOf(presentQ);
    lMag   = magOf(lateQ);
    isPeak = freshQ && (eMag < pMag) && (lMag < pMag) && (pMag >= threshold);
  end

  // Stage 1: sample window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      earlyQ   <= '0;
      presentQ <= '0;
      lateQ    <= '0;
      fillQ    <= '0;
      freshQ   <= 1'b0;
    end else begin
      freshQ <= 1'b0;
      if (sampleStb) begin
        earlyQ   <= presentQ;
        presentQ <= lateQ;
        lateQ    <= sampleIn;
        if (fillQ != 2'd3) fillQ <= fillQ + 2'd1;
        freshQ   <= (fillQ >= 2'd2);
      end
    end
  end

  // Stage 2: registered decision
  always_ff @(posedge clk) begin
    if (!rstN) begin
      peakQ  <= 1'b0;
      sliceQ <= 1'b0;
      tickQ  <= 1'b0;
    end else begin
      peakQ <= isPeak;
      tickQ <= sampleStb;
      if (isPeak) sliceQ <= ~presentQ[MSB];
    end
  end

  assign evt = '{peak: peakQ, slice: sliceQ, tick: tickQ};

  AST_PEAK_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    peakQ |=> !peakQ); // R2
  AST_PEAK_FROM_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    peakQ |-> $past(sampleStb, 2)); // R11
endmodule

// File: rtl/elsSyncCtrl.sv
module elsSyncCtrl
  import elsPkg::*;
#(
  parameter int              PRE_LEN    = 16,
  parameter logic [PRE_LEN-1:0] PREAMBLE = 16'hE25B,
  parameter int              LOSS_LIMIT = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  peakEvt_t evt,
  output logic     syncLock,
  output logic     dataBit,
  output logic     dataValid
);
  localparam int GAP_W = $clog2(LOSS_LIMIT + 1);

  logic [PRE_LEN-1:0] histQ, patQ, histNext;
  logic [GAP_W-1:0]   gapQ;
  logic               lockQ, validQ, bitQ, lossHit;

  always_comb begin
    histNext = {histQ[PRE_LEN-2:0], evt.slice};
    lossHit  = lockQ && evt.tick && !evt.peak && (gapQ == GAP_W'(LOSS_LIMIT - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      histQ  <= '0;
      patQ   <= PREAMBLE;
      gapQ   <= '0;
      lockQ  <= 1'b0;
      validQ <= 1'b0;
      bitQ   <= 1'b0;
    end else begin
      validQ <= 1'b0;
      if (evt.peak) begin
        gapQ  <= '0;
        histQ <= histNext;
        if (lockQ) begin
          validQ <= 1'b1;
          bitQ   <= evt.slice;
        end else if (histNext == patQ) begin
          lockQ <= 1'b1;
        end
      end else if (evt.tick) begin
        if (lossHit) begin
          lockQ <= 1'b0;
          histQ <= '0;
          gapQ  <= '0;
        end else if (gapQ != GAP_W'(LOSS_LIMIT)) begin
          gapQ <= gapQ + 1'b1;
        end
      end
    end
  end

  assign syncLock  = lockQ;
  assign dataBit   = bitQ;
  assign dataValid = validQ;

  AST_VALID_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    validQ |-> lockQ); // R7
  AST_VALID_AFTER_PEAK: assert property (@(posedge clk) disable iff (!rstN)
    validQ |-> $past(evt.peak)); // R8
  AST_LOCK_ON_PEAK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockQ) |-> $past(evt.peak)); // R6
  AST_LOSS_ON_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockQ) |-> $past(evt.tick && !evt.peak)); // R9
endmodule

// File: rtl/elsPeakSync.sv
module elsPeakSync #(
  parameter int                 DATA_W          = 13,
  parameter int                 SAMPLES_PER_BIT = 8,
  parameter int                 PRE_LEN         = 16,
  parameter logic [PRE_LEN-1:0] PREAMBLE        = 16'hE25B
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [DATA_W-1:0] sampleIn,
  input  logic                     sampleStb,
  input  logic        [DATA_W-1:0] threshold,
  output logic                     peakStb,
  output logic                     syncLock,
  output logic                     dataBit,
  output logic                     dataValid
);
  localparam int LOSS_LIMIT = 2 * SAMPLES_PER_BIT;

  elsPkg::peakEvt_t evt;

  elsPeakPath #(.DATA_W(DATA_W)) u_path (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleStb(sampleStb),
    .threshold(threshold), .evt(evt)
  );

  elsSyncCtrl #(.PRE_LEN(PRE_LEN), .PREAMBLE(PREAMBLE), .LOSS_LIMIT(LOSS_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt),
    .syncLock(syncLock), .dataBit(dataBit), .dataValid(dataValid)
  );

  assign peakStb = evt.peak;
endmodule

// File: tb/elsPeakSync_tb.sv
module elsPeakSync_tb;
  localparam int DW = 13, SPB = 8, LIM = 2 * SPB;
  localparam logic [15:0] PRE = 16'hE25B;

  logic clk = 1'b0, rstN = 1'b0;
  logic signed [DW-1:0] sampleIn = '0;
  logic sampleStb = 1'b0;
  logic [DW-1:0] threshold = 13'd20;
  logic peakStb, syncLock, dataBit, dataValid;

  elsPeakSync u_dut (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleStb(sampleStb),
    .threshold(threshold), .peakStb(peakStb), .syncLock(syncLock),
    .dataBit(dataBit), .dataValid(dataValid)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  int mE = 0, mP = 0, mL = 0, mFill = 0, mGap = 0;
  bit mLock = 0;
  bit [15:0] mHist = '0;
  bit expPeak, expValid, expBit;
  int lastPeak = 0, validCnt = 0;

  function automatic int magF(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check1(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic modelStep(int v);
    bit s;
    mE = mP; mP = mL; mL = v;
    if (mFill < 3) mFill++;
    expPeak = (mFill == 3) && magF(mE) < magF(mP) && magF(mL) < magF(mP) &&
              magF(mP) >= int'(threshold);
    s = (mP >= 0);
    expValid = 0;
    if (mLock && mGap == LIM - 1) begin mLock = 0; mHist = '0; mGap = 0; end
    else if (mGap != LIM) mGap++;
    if (expPeak) begin
      mGap = 0;
      mHist = {mHist[14:0], s};
      if (mLock) begin expValid = 1; expBit = s; end
      else if (mHist == PRE) mLock = 1;
    end
  endtask

  task automatic sendSample(int v);
    @(negedge clk);
    sampleIn = DW'(v); sampleStb = 1'b1; modelStep(v);
    @(negedge clk);
    sampleStb = 1'b0; sampleIn = DW'($urandom);   // R11: garbage while idle
    @(negedge clk);
    lastPeak = int'(peakStb);
    check1("R2/R3/R4 peakStb", int'(peakStb), int'(expPeak));
    @(negedge clk);
    check1("R6/R9 syncLock", int'(syncLock), int'(mLock));
    check1("R7/R8 dataValid", int'(dataValid), int'(expValid));
    if (expValid) check1("R5/R8 dataBit", int'(dataBit), int'(expBit));
    if (dataValid) validCnt++;
  endtask

  task automatic sendBit(bit b, int step);
    for (int k = 1; k <= SPB; k++) sendSample(b ? k * step : -k * step);
  endtask

  task automatic sendPre(int first, int last);
    for (int i = first; i >= last; i--) sendBit(PRE[i], 8 + int'($urandom % 33));
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check1("R1 peakStb reset", int'(peakStb), 0);
    check1("R1 syncLock reset", int'(syncLock), 0);
    check1("R1 dataValid reset", int'(dataValid), 0);

    // R3/R4 directed magnitude corners
    sendSample(0); sendSample(100); sendSample(100); sendSample(100); sendSample(0);
    check1("R3 plateau no peak", lastPeak, 0);
    sendSample(0); sendSample(19); sendSample(0);
    check1("R3 below threshold", lastPeak, 0);
    sendSample(20); sendSample(0);
    check1("R3 equal threshold peaks", lastPeak, 1);
    sendSample(-10); sendSample(-4096); sendSample(-10);
    check1("R4 most negative peaks", lastPeak, 1);

    // random bits, then preamble, then data
    for (int i = 0; i < 10; i++) sendBit(1'($urandom), 8 + int'($urandom % 33));
    validCnt = 0;
    sendPre(15, 0);
    sendSample(0);
    check1("R6 lock after preamble", int'(syncLock), 1);
    check1("R7 no data before lock", validCnt, 0);
    validCnt = 0;
    for (int i = 0; i < 20; i++) sendBit(1'($urandom), 8 + int'($urandom % 33));
    sendSample(0);
    check1("R8 one bit per peak", validCnt, 20);

    // R11: idle strobes with wild input
    begin
      int pk = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk); sampleIn = DW'($urandom); if (peakStb) pk++;
      end
      check1("R11 no peak without strobe", pk, 0);
      check1("R11 lock kept while idle", int'(syncLock), 1);
    end

    // R9 loss of lock
    for (int i = 0; i < 5; i++) sendSample(0);
    check1("R9 lock held over short gap", int'(syncLock), 1);
    for (int i = 0; i < LIM; i++) sendSample(0);
    check1("R9 lock lost after long gap", int'(syncLock), 0);

    // R10 partial then full preamble
    sendPre(7, 0); sendSample(0);
    check1("R10 partial preamble no lock", int'(syncLock), 0);
    sendPre(15, 0); sendSample(0);
    check1("R10 relock on full preamble", int'(syncLock), 1);
    for (int i = 0; i < 8; i++) sendBit(1'($urandom), 8 + int'($urandom % 33));
    sendSample(0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule